// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block raises interrupt flags for a memory that two ports share and use for messages. It watches each port's address, select, write strobe and output enable on every clock edge. Two fixed addresses at the top of the address space act as mailboxes. The all-ones address belongs to the right port. The all-ones-minus-one address belongs to the left port. When one port writes into the other port's mailbox, a flag is raised for the port that owns that mailbox. The owner drops its flag by reading its own mailbox. Each flag drives an active-low interrupt line.

Each port's flag is a two-state machine with the states `FLAG_IDLE` and `FLAG_PENDING`. The `RAISE` transition goes from `FLAG_IDLE` to `FLAG_PENDING` on a set event. The `ACK` transition goes from `FLAG_PENDING` to `FLAG_IDLE` on a clear event, provided no set event occurs in the same cycle. In every other case the state holds.

A set event is a write by the peer port to the owner's mailbox: the peer's select and write strobe are high and its address equals the owner's mailbox address. A clear event is a read by the owner of its own mailbox: the owner's select and output enable are high, its write strobe is low, and its address equals its own mailbox address. All events are sampled on the rising clock edge, and the interrupt line reflects the new state one cycle after the event. The memory array is not part of this block, and neither are any semaphores.

Top module: `mbx_irq_flags`

## Requirements
- R1: The right port's mailbox is address 2^ADDR_W-1 (all ones). A left-port write to it (lt_en=1, lt_we=1) drives rt_irq_n low after the next rising edge.
- R2: The left port's mailbox is address 2^ADDR_W-2 (all ones except bit 0). A right-port write to it (rt_en=1, rt_we=1) drives lt_irq_n low after the next rising edge.
- R3: Both interrupt lines are active low. While rst_n is low and after reset, both lines are high.
- R4: A port's flag clears one cycle after that port reads its own mailbox (en=1, oe=1, we=0), and its line returns high.
- R5: If a set event and a clear event hit the same flag in the same cycle, the flag is set or stays set.
- R6: A port writing its own mailbox, or reading the other port's mailbox, changes neither interrupt line.
- R7: A read with en=0 or oe=0 does not clear a flag. A write with en=0 does not set a flag.
- R8: With no set or clear event for a flag, its line keeps its value, whatever accesses go to other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lt_addr | input | ADDR_W | Left port address |
| lt_en | input | 1 | Left port select, active high |
| lt_we | input | 1 | Left port write strobe, high = write |
| lt_oe | input | 1 | Left port output enable, active high |
| rt_addr | input | ADDR_W | Right port address |
| rt_en | input | 1 | Right port select, active high |
| rt_we | input | 1 | Right port write strobe, high = write |
| rt_oe | input | 1 | Right port output enable, active high |
| lt_irq_n | output | 1 | Left port interrupt, active low |
| rt_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The bench builds the block with ADDR_W=4, so the two mailboxes make up one eighth of the address space. Random addresses are also biased toward the top two locations. With this setting, collisions become frequent: a set and a clear on the same flag in one cycle, reads missing their select or enable, and a port writing its own mailbox. A reference model in the bench predicts both lines every cycle. Directed sequences pin down the priority and ignore cases.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    localparam int NUM_PORTS = 2;
endpackage

// File: rtl/mbx_evt_decode.sv
// Turns one port pair's strobes into set/clear events for the owner's flag.
module mbx_evt_decode #(
    parameter int               ADDR_W = 13,
    parameter logic [ADDR_W-1:0] BOX   = '1
) (
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              own_en,
    input  logic              own_we,
    input  logic              own_oe,
    input  logic [ADDR_W-1:0] peer_addr,
    input  logic              peer_en,
    input  logic              peer_we,
    output logic              set_evt,
    output logic              clr_evt
);
    logic own_hit;
    logic peer_hit;

    always_comb begin
        own_hit  = (own_addr == BOX);
        peer_hit = (peer_addr == BOX);
        set_evt  = peer_en && peer_we && peer_hit;
        clr_evt  = own_en && own_oe && !own_we && own_hit;
    end
endmodule

// File: rtl/mbx_flag_fsm.sv
// Two-state flag: RAISE on set, ACK on clear; set wins.
module mbx_flag_fsm
    import mbx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic irq_n
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (set_evt) state_d = FLAG_PENDING;      // RAISE
            end
            FLAG_PENDING: begin
                if (clr_evt && !set_evt) state_d = FLAG_IDLE;  // ACK
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        irq_n = (state_q != FLAG_PENDING);
    end
endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_en,
    input  logic              lt_we,
    input  logic              lt_oe,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_en,
    input  logic              rt_we,
    input  logic              rt_oe,
    output logic              lt_irq_n,
    output logic              rt_irq_n
);
    // index 0 = left port, index 1 = right port
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
    localparam logic [ADDR_W-1:0] LT_BOX   = TOP_ADDR - 1'b1;
    localparam logic [ADDR_W-1:0] RT_BOX   = TOP_ADDR;

    logic [NUM_PORTS-1:0][ADDR_W-1:0] p_addr;
    logic [NUM_PORTS-1:0]             p_en;
    logic [NUM_PORTS-1:0]             p_we;
    logic [NUM_PORTS-1:0]             p_oe;
    logic [NUM_PORTS-1:0]             p_set;
    logic [NUM_PORTS-1:0]             p_clr;
    logic [NUM_PORTS-1:0]             p_irq_n;

    always_comb begin
        p_addr[0] = lt_addr;  p_addr[1] = rt_addr;
        p_en[0]   = lt_en;    p_en[1]   = rt_en;
        p_we[0]   = lt_we;    p_we[1]   = rt_we;
        p_oe[0]   = lt_oe;    p_oe[1]   = rt_oe;
    end

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        localparam int                PEER = NUM_PORTS - 1 - i;
        localparam logic [ADDR_W-1:0] BOX  = (i == 0) ? LT_BOX : RT_BOX;

        mbx_evt_decode #(
            .ADDR_W (ADDR_W),
            .BOX    (BOX)
        ) u_dec (
            .own_addr  (p_addr[i]),
            .own_en    (p_en[i]),
            .own_we    (p_we[i]),
            .own_oe    (p_oe[i]),
            .peer_addr (p_addr[PEER]),
            .peer_en   (p_en[PEER]),
            .peer_we   (p_we[PEER]),
            .set_evt   (p_set[i]),
            .clr_evt   (p_clr[i])
        );

        mbx_flag_fsm u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (p_set[i]),
            .clr_evt (p_clr[i]),
            .irq_n   (p_irq_n[i])
        );
    end

    assign lt_irq_n = p_irq_n[0];
    assign rt_irq_n = p_irq_n[1];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              lt_en,
    input logic              lt_we,
    input logic              lt_oe,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              rt_en,
    input logic              rt_we,
    input logic              rt_oe,
    input logic              lt_irq_n,
    input logic              rt_irq_n
);
    localparam logic [ADDR_W-1:0] RT_MB = '1;
    localparam logic [ADDR_W-1:0] LT_MB = RT_MB - 1'b1;

    logic wr_to_rt, wr_to_lt, rd_rt, rd_lt;
    always_comb begin
        wr_to_rt = lt_en && lt_we && (lt_addr == RT_MB);
        wr_to_lt = rt_en && rt_we && (rt_addr == LT_MB);
        rd_rt    = rt_en && rt_oe && !rt_we && (rt_addr == RT_MB);
        rd_lt    = lt_en && lt_oe && !lt_we && (lt_addr == LT_MB);
    end

    // R3
    p_reset_high_r3: assert property (@(posedge clk)
        !rst_n |=> (lt_irq_n && rt_irq_n));
    // R1, R5
    p_set_rt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_to_rt |=> !rt_irq_n);
    // R2, R5
    p_set_lt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_to_lt |=> !lt_irq_n);
    // R4
    p_clear_rt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rt && !wr_to_rt) |=> rt_irq_n);
    p_clear_lt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lt && !wr_to_lt) |=> lt_irq_n);
    // R8
    p_hold_rt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_to_rt && !rd_rt) |=> $stable(rt_irq_n));
    p_hold_lt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_to_lt && !rd_lt) |=> $stable(lt_irq_n));
endmodule

bind mbx_irq_flags mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_mbx_irq_flags.sv
module tb_mbx_irq_flags;
    localparam int AW = 4;
    localparam logic [AW-1:0] RT_MB = '1;
    localparam logic [AW-1:0] LT_MB = RT_MB - 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic lt_en = 0, lt_we = 0, lt_oe = 0;
    logic rt_en = 0, rt_we = 0, rt_oe = 0;
    logic lt_irq_n, rt_irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit m_lt = 0, m_rt = 0;  // model: 1 = pending
    bit done = 0;

    always #10 clk = ~clk;

    mbx_irq_flags #(.ADDR_W(AW)) dut (.*);

    function automatic bit next_flag(bit cur, bit set_e, bit clr_e);
        if (set_e) return 1'b1;
        if (clr_e) return 1'b0;
        return cur;
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // drive at negedge, model update, advance one edge, sample at negedge
    task automatic step(logic [AW-1:0] la, logic le, logic lw, logic lo,
                        logic [AW-1:0] ra, logic re, logic rw, logic ro,
                        string req);
        lt_addr = la; lt_en = le; lt_we = lw; lt_oe = lo;
        rt_addr = ra; rt_en = re; rt_we = rw; rt_oe = ro;
        if (rst_n) begin
            m_rt = next_flag(m_rt, le && lw && la == RT_MB,
                             re && ro && !rw && ra == RT_MB);
            m_lt = next_flag(m_lt, re && rw && ra == LT_MB,
                             le && lo && !lw && la == LT_MB);
        end else begin
            m_rt = 0; m_lt = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check(req, lt_irq_n, ~m_lt);
        check(req, rt_irq_n, ~m_rt);
    endtask

    task automatic idle(string req);
        step('0, 0, 0, 0, '0, 0, 0, 0, req);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1234;
        void'($urandom(seed));
        @(negedge clk);
        idle("R3 reset");
        idle("R3 reset");
        rst_n = 1'b1;
        idle("R3 after reset");

        // R1 left sets right
        step(RT_MB, 1, 1, 0, '0, 0, 0, 0, "R1 set right");
        idle("R8 hold");
        // R7 right reads own box without oe / en
        step('0, 0, 0, 0, RT_MB, 1, 0, 0, "R7 no oe");
        step('0, 0, 0, 0, RT_MB, 0, 0, 1, "R7 no en");
        // R6 right reads left box
        step('0, 0, 0, 0, LT_MB, 1, 0, 1, "R6 read peer box");
        // R4 clear
        step('0, 0, 0, 0, RT_MB, 1, 0, 1, "R4 clear right");
        // R2 right sets left
        step('0, 0, 0, 0, LT_MB, 1, 1, 0, "R2 set left");
        // R6 left writes own box, right writes own box
        step(LT_MB, 1, 1, 0, RT_MB, 1, 1, 0, "R6 own writes");
        // R7 write without enable
        step(RT_MB, 0, 1, 0, '0, 0, 0, 0, "R7 write no en");
        // R5 set and clear same cycle on left flag
        step(LT_MB, 1, 0, 1, LT_MB, 1, 1, 0, "R5 set wins");
        step(LT_MB, 1, 0, 1, '0, 0, 0, 0, "R4 clear left");
        // R5 from idle
        step(LT_MB, 1, 0, 1, LT_MB, 1, 1, 0, "R5 set wins idle");
        step(LT_MB, 1, 0, 1, '0, 0, 0, 0, "R4 clear left");

        for (int k = 0; k < 600; k++) begin
            logic [AW-1:0] la, ra;
            la = ($urandom % 3 == 0) ? AW'($urandom) : (($urandom % 2) ? RT_MB : LT_MB);
            ra = ($urandom % 3 == 0) ? AW'($urandom) : (($urandom % 2) ? RT_MB : LT_MB);
            step(la, 1'($urandom), 1'($urandom), 1'($urandom),
                 ra, 1'($urandom), 1'($urandom), 1'($urandom),
                 "random R1 R2 R4 R5 R6 R7 R8");
        end

        // R3 reset mid-run
        step(RT_MB, 1, 1, 0, LT_MB, 1, 1, 0, "R1 R2 both set");
        rst_n = 1'b0;
        idle("R3 reset clears");
        rst_n = 1'b1;
        idle("R3 after reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule